// File: doc/BRIEF.md
# Floppy Controller Command Sequencer

This block is the host-side command engine of a floppy disk controller. The host pushes an opcode and its argument bytes through one byte-wide data port, pulls status bytes back through the same port, and follows a main status byte that tells it when a byte may move and in which direction. Each opcode has its own number of argument bytes and its own number of status bytes. The ready and direction bits in the main status byte walk the host from the argument phase, through a busy execution phase, to the status phase and back to idle.

Execution is modelled rather than performed. Seeks, recalibrations and single-sector transfers hold the engine busy for a fixed number of cycles. After that they raise an interrupt. A cylinder register per drive records where each head was last moved. A separate digital output register drives the drive-select and motor-enable lines. It can also mask the interrupt output and hold the whole engine in reset.

The disk data path, the media encoding and the DMA transfer itself are outside the block.

Top module: `fdc_cmd_seq`

## Requirements
- R1: The main status byte `msr` uses bit 7 for ready, bit 6 for direction (1 means the host reads) and bit 4 for busy. Bits 5 and 3:0 read 0. It reads 0x80 when idle, 0x90 while argument bytes are being taken, 0x10 during execution and 0xD0 while status bytes are pending.
- R2: A data-port write is taken only when `msr[7:6]` is 10, and a data-port read only when it is 11. Any other access is ignored and leaves the phase unchanged. `dat_rdata` is 0x00 outside the status phase.
- R3: Sector read (0x46) and sector write (0xC5) take 8 argument bytes, in this order:
  - byte 0: head in bit 2, drive in bits 1:0
  - byte 1: cylinder C
  - byte 2: head H
  - byte 3: sector R
  - byte 4: size code N
  - byte 5: last sector of the track E
  - byte 6: gap length (ignored)
  - byte 7: data length (ignored)

  After execution they return 7 bytes: ST0, ST1, ST2, C, H, R', N. ST0 is {code[1:0], 3'b000, head, drive[1:0]}. ST2 is 0.
  - If R differs from E: code is 00, ST1 is 0 and R' is R+1.
  - If R equals E: code is 01, ST1 is 0x80 (end of cylinder) and R' is 1.
- R4: Seek (0x0F) takes a drive byte (drive in bits 1:0) and a target cylinder. Recalibrate (0x07) takes only the drive byte and targets cylinder 0. Neither command has a status phase. On completion the drive's cylinder register takes the target and the interrupt is raised.
- R5: Sense interrupt status (0x08) takes no arguments and returns two bytes.
  - After a seek or recalibrate has completed, it returns 0x20 | drive and then that command's target cylinder, and it consumes the pending record.
  - With nothing pending, it returns 0x80 and then 0x00.
- R6: The remaining known opcodes:
  - Specify (0x03) takes 2 argument bytes and returns to idle with no status.
  - Sense drive status (0x04) takes one byte (head in bit 2, drive in bits 1:0) and returns one byte. That byte is 0x20 | (0x10 if the drive's cylinder is 0) | head<<2 | drive.
  - Version (0x10) returns the single byte 0x90.
- R7: Any other opcode goes straight to a status phase that returns the single byte 0x80.
- R8: The interrupt flag is set when execution finishes. It is cleared when the first status byte is read or when a sense interrupt status opcode is taken. `irq` shows the flag only while digital output register bit 3 is 1.
- R9: The digital output register is written through `dor_wr` and drives `dor_q` directly.
  - Bits 1:0 drive `drv_sel`, and bit 4+n drives `motor_en[n]`.
  - While bit 2 is 0 the engine is held in reset: `msr` reads 0x00, `irq` is 0, data-port writes are ignored, and any command and pending record is dropped. Per-drive cylinders are kept.
  - A write that clears bit 2 on the same edge that execution would finish wins, so no cylinder update and no interrupt occur.
- R10: Execution lasts exactly `EXEC_CYCLES` clock cycles. After the edge that takes the last argument byte, `msr` reads 0x10 for `EXEC_CYCLES` cycles before it changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dor_wr | input | 1 | Write strobe for the digital output register |
| dor_wdata | input | 8 | Digital output register write value |
| dor_q | output | 8 | Digital output register contents |
| drv_sel | output | 2 | Selected drive (register bits 1:0) |
| motor_en | output | N_DRIVES | Motor enables (register bits 4+n) |
| dat_wr | input | 1 | Data-port write strobe |
| dat_rd | input | 1 | Data-port read strobe |
| dat_wdata | input | 8 | Byte written to the data port |
| dat_rdata | output | 8 | Status byte presented for reading |
| msr | output | 8 | Main status byte |
| irq | output | 1 | Completion interrupt, gated by register bit 3 |

## Verification
Two functions can meet on one clock edge: execution finishing and a digital output register write that drops the reset bit. The bench starts a seek from a nonzero cylinder to cylinder 0. It then counts `EXEC_CYCLES` edges from the last argument byte and places the register write exactly on the finishing edge. It then judges that `msr` and `irq` are both 0, and after reset is released that no interrupt is pending. It also checks that sense interrupt status reports nothing pending and that sense drive status still shows the drive away from cylinder 0.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

    localparam int RES_MAX = 7;

    localparam logic [7:0] OPC_READ     = 8'h46;
    localparam logic [7:0] OPC_WRITE    = 8'hC5;
    localparam logic [7:0] OPC_SEEK     = 8'h0F;
    localparam logic [7:0] OPC_RECAL    = 8'h07;
    localparam logic [7:0] OPC_SNS_INT  = 8'h08;
    localparam logic [7:0] OPC_SPECIFY  = 8'h03;
    localparam logic [7:0] OPC_SNS_DRV  = 8'h04;
    localparam logic [7:0] OPC_VERSION  = 8'h10;

    localparam logic [7:0] VERSION_ID   = 8'h90;
    localparam logic [7:0] ST0_INVALID  = 8'h80;
    localparam logic [7:0] ST1_END_CYL  = 8'h80;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_PARAM,
        PH_EXEC,
        PH_RESULT
    } phase_e;

    typedef enum logic [2:0] {
        K_XFER,
        K_SEEK,
        K_RECAL,
        K_SNS_INT,
        K_SPECIFY,
        K_SNS_DRV,
        K_VERSION,
        K_INVALID
    } kind_e;

    typedef struct packed {
        logic       rqm;
        logic       dio;
        logic       ndma;
        logic       busy;
        logic [3:0] drv_busy;
    } msr_t;

    function automatic kind_e decode_op(input logic [7:0] op);
        case (op)
            OPC_READ, OPC_WRITE: return K_XFER;
            OPC_SEEK:            return K_SEEK;
            OPC_RECAL:           return K_RECAL;
            OPC_SNS_INT:         return K_SNS_INT;
            OPC_SPECIFY:         return K_SPECIFY;
            OPC_SNS_DRV:         return K_SNS_DRV;
            OPC_VERSION:         return K_VERSION;
            default:             return K_INVALID;
        endcase
    endfunction

    function automatic logic [3:0] param_len(input kind_e k);
        case (k)
            K_XFER:    return 4'd8;
            K_SEEK:    return 4'd2;
            K_RECAL:   return 4'd1;
            K_SPECIFY: return 4'd2;
            K_SNS_DRV: return 4'd1;
            default:   return 4'd0;
        endcase
    endfunction

    function automatic logic [7:0] make_st0(input logic [1:0] code, input logic seek_end,
                                            input logic head, input logic [1:0] drv);
        return {code, seek_end, 2'b00, head, drv};
    endfunction

    function automatic msr_t phase_status(input phase_e ph);
        msr_t s;
        s = '0;
        case (ph)
            PH_IDLE:   s.rqm = 1'b1;
            PH_PARAM:  begin s.rqm = 1'b1; s.busy = 1'b1; end
            PH_EXEC:   s.busy = 1'b1;
            PH_RESULT: begin s.rqm = 1'b1; s.dio = 1'b1; s.busy = 1'b1; end
            default:   s = '0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/fdc_dor_reg.sv
module fdc_dor_reg #(
    parameter int N_DRIVES = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr,
    input  logic [7:0]          wdata,
    output logic [7:0]          q,
    output logic                hold,
    output logic [1:0]          drv_sel,
    output logic [N_DRIVES-1:0] motor_en
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= 8'h00;
        else if (wr)
            q <= wdata;
    end

    assign hold    = ~q[2];
    assign drv_sel = q[1:0];

    for (genvar i = 0; i < N_DRIVES; i++) begin : g_motor
        assign motor_en[i] = q[4+i];
    end
endmodule

// File: rtl/fdc_exec_timer.sv
module fdc_exec_timer #(
    parameter int EXEC_CYCLES = 16
) (
    input  logic clk,
    input  logic clr,
    input  logic start,
    output logic done
);
    localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

    logic             active_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (clr) begin
            active_q <= 1'b0;
            cnt_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            cnt_q    <= CNT_W'(EXEC_CYCLES - 1);
        end else if (active_q) begin
            if (cnt_q == '0)
                active_q <= 1'b0;
            else
                cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = active_q && (cnt_q == '0);
endmodule

// File: rtl/fdc_track_bank.sv
module fdc_track_bank #(
    parameter int N_DRIVES = 4,
    parameter int DRV_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [DRV_W-1:0] wdrv,
    input  logic [7:0]       wcyl,
    input  logic [DRV_W-1:0] rdrv,
    output logic [7:0]       rcyl
);
    logic [7:0] cyl_q [N_DRIVES];

    for (genvar i = 0; i < N_DRIVES; i++) begin : g_drive
        always_ff @(posedge clk) begin
            if (rst)
                cyl_q[i] <= 8'h00;
            else if (we && (wdrv == DRV_W'(i)))
                cyl_q[i] <= wcyl;
        end
    end

    always_comb begin
        rcyl = 8'h00;
        for (int i = 0; i < N_DRIVES; i++)
            if (rdrv == DRV_W'(i))
                rcyl = cyl_q[i];
    end
endmodule

// File: rtl/fdc_phase_ctl.sv
module fdc_phase_ctl
    import fdc_seq_pkg::*;
#(
    parameter int DRV_W = 2
) (
    input  logic             clk,
    input  logic             core_rst,
    input  logic             hold,
    input  logic             dat_wr,
    input  logic             dat_rd,
    input  logic [7:0]       dat_wdata,
    output logic [7:0]       dat_rdata,
    output logic [7:0]       msr,
    output logic             irq_pend,
    output logic             timer_start,
    input  logic             timer_done,
    output logic             trk_we,
    output logic [DRV_W-1:0] trk_wdrv,
    output logic [7:0]       trk_wcyl,
    output logic [DRV_W-1:0] trk_rdrv,
    input  logic [7:0]       trk_rcyl
);
    phase_e     phase_q;
    kind_e      kind_q;
    logic [2:0] sel_q;
    logic [7:0] prm_q [1:5];
    logic [2:0] prm_idx_q;
    logic [3:0] prm_len_q;
    logic [7:0] res_q [RES_MAX];
    logic [2:0] res_idx_q;
    logic [2:0] res_last_q;
    logic       irq_q;
    logic       sns_vld_q;
    logic [7:0] sns_st0_q;
    logic [7:0] sns_cyl_q;

    logic       wr_ok, rd_ok, last_prm, eoc, execs;
    kind_e      op_kind;
    logic [7:0] seek_tgt, st3;
    msr_t       ms;

    assign wr_ok    = dat_wr && !hold && (phase_q == PH_IDLE || phase_q == PH_PARAM);
    assign rd_ok    = dat_rd && !hold && (phase_q == PH_RESULT);
    assign op_kind  = decode_op(dat_wdata);
    assign last_prm = wr_ok && (phase_q == PH_PARAM) &&
                      ({1'b0, prm_idx_q} == prm_len_q - 4'd1);
    assign execs    = (kind_q == K_XFER) || (kind_q == K_SEEK) || (kind_q == K_RECAL);
    assign eoc      = (prm_q[3] == prm_q[5]);
    assign seek_tgt = (kind_q == K_SEEK) ? prm_q[1] : 8'h00;
    assign st3      = {2'b00, 1'b1, (trk_rcyl == 8'h00), 1'b0, dat_wdata[2:0]};

    assign timer_start = last_prm && execs;
    assign trk_we      = timer_done && !core_rst && (kind_q == K_SEEK || kind_q == K_RECAL);
    assign trk_wdrv    = sel_q[DRV_W-1:0];
    assign trk_wcyl    = seek_tgt;
    assign trk_rdrv    = dat_wdata[DRV_W-1:0];

    assign ms        = phase_status(phase_q);
    assign msr       = hold ? 8'h00 : ms;
    assign dat_rdata = (!hold && phase_q == PH_RESULT) ? res_q[res_idx_q] : 8'h00;
    assign irq_pend  = irq_q;

    always_ff @(posedge clk) begin
        if (core_rst) begin
            phase_q    <= PH_IDLE;
            kind_q     <= K_INVALID;
            sel_q      <= 3'b000;
            prm_idx_q  <= '0;
            prm_len_q  <= '0;
            res_idx_q  <= '0;
            res_last_q <= '0;
            irq_q      <= 1'b0;
            sns_vld_q  <= 1'b0;
            sns_st0_q  <= 8'h00;
            sns_cyl_q  <= 8'h00;
        end else begin
            case (phase_q)
                PH_IDLE: if (wr_ok) begin
                    kind_q    <= op_kind;
                    prm_len_q <= param_len(op_kind);
                    prm_idx_q <= '0;
                    res_idx_q <= '0;
                    case (op_kind)
                        K_SNS_INT: begin
                            irq_q      <= 1'b0;
                            res_q[0]   <= sns_vld_q ? sns_st0_q : ST0_INVALID;
                            res_q[1]   <= sns_vld_q ? sns_cyl_q : 8'h00;
                            sns_vld_q  <= 1'b0;
                            res_last_q <= 3'd1;
                            phase_q    <= PH_RESULT;
                        end
                        K_VERSION: begin
                            res_q[0]   <= VERSION_ID;
                            res_last_q <= 3'd0;
                            phase_q    <= PH_RESULT;
                        end
                        K_INVALID: begin
                            res_q[0]   <= ST0_INVALID;
                            res_last_q <= 3'd0;
                            phase_q    <= PH_RESULT;
                        end
                        default: phase_q <= PH_PARAM;
                    endcase
                end
                PH_PARAM: if (wr_ok) begin
                    if (prm_idx_q == 3'd0)
                        sel_q <= dat_wdata[2:0];
                    else if (prm_idx_q <= 3'd5)
                        prm_q[prm_idx_q] <= dat_wdata;
                    prm_idx_q <= prm_idx_q + 1'b1;
                    if (last_prm) begin
                        case (kind_q)
                            K_SPECIFY: phase_q <= PH_IDLE;
                            K_SNS_DRV: begin
                                res_q[0]   <= st3;
                                res_last_q <= 3'd0;
                                phase_q    <= PH_RESULT;
                            end
                            default: phase_q <= PH_EXEC;
                        endcase
                    end
                end
                PH_EXEC: if (timer_done) begin
                    irq_q <= 1'b1;
                    if (kind_q == K_XFER) begin
                        res_q[0]   <= make_st0(eoc ? 2'b01 : 2'b00, 1'b0, sel_q[2], sel_q[1:0]);
                        res_q[1]   <= eoc ? ST1_END_CYL : 8'h00;
                        res_q[2]   <= 8'h00;
                        res_q[3]   <= prm_q[1];
                        res_q[4]   <= prm_q[2];
                        res_q[5]   <= eoc ? 8'h01 : prm_q[3] + 8'h01;
                        res_q[6]   <= prm_q[4];
                        res_last_q <= 3'd6;
                        phase_q    <= PH_RESULT;
                    end else begin
                        sns_vld_q <= 1'b1;
                        sns_st0_q <= make_st0(2'b00, 1'b1, 1'b0, sel_q[1:0]);
                        sns_cyl_q <= seek_tgt;
                        phase_q   <= PH_IDLE;
                    end
                end
                PH_RESULT: if (rd_ok) begin
                    if (res_idx_q == 3'd0)
                        irq_q <= 1'b0;
                    if (res_idx_q == res_last_q)
                        phase_q <= PH_IDLE;
                    else
                        res_idx_q <= res_idx_q + 1'b1;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fdc_cmd_seq.sv
module fdc_cmd_seq
    import fdc_seq_pkg::*;
#(
    parameter int N_DRIVES    = 4,
    parameter int EXEC_CYCLES = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                dor_wr,
    input  logic [7:0]          dor_wdata,
    output logic [7:0]          dor_q,
    output logic [1:0]          drv_sel,
    output logic [N_DRIVES-1:0] motor_en,
    input  logic                dat_wr,
    input  logic                dat_rd,
    input  logic [7:0]          dat_wdata,
    output logic [7:0]          dat_rdata,
    output logic [7:0]          msr,
    output logic                irq
);
    localparam int DRV_W = (N_DRIVES > 1) ? $clog2(N_DRIVES) : 1;

    logic             hold, core_rst, irq_pend;
    logic             timer_start, timer_done;
    logic             trk_we;
    logic [DRV_W-1:0] trk_wdrv, trk_rdrv;
    logic [7:0]       trk_wcyl, trk_rcyl;

    fdc_dor_reg #(.N_DRIVES(N_DRIVES)) u_dor (
        .clk(clk), .rst(rst), .wr(dor_wr), .wdata(dor_wdata),
        .q(dor_q), .hold(hold), .drv_sel(drv_sel), .motor_en(motor_en)
    );

    assign core_rst = rst | hold | (dor_wr & ~dor_wdata[2]);

    fdc_exec_timer #(.EXEC_CYCLES(EXEC_CYCLES)) u_timer (
        .clk(clk), .clr(core_rst), .start(timer_start), .done(timer_done)
    );

    fdc_track_bank #(.N_DRIVES(N_DRIVES), .DRV_W(DRV_W)) u_track (
        .clk(clk), .rst(rst), .we(trk_we), .wdrv(trk_wdrv), .wcyl(trk_wcyl),
        .rdrv(trk_rdrv), .rcyl(trk_rcyl)
    );

    fdc_phase_ctl #(.DRV_W(DRV_W)) u_ctl (
        .clk(clk), .core_rst(core_rst), .hold(hold),
        .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_wdata(dat_wdata), .dat_rdata(dat_rdata),
        .msr(msr), .irq_pend(irq_pend),
        .timer_start(timer_start), .timer_done(timer_done),
        .trk_we(trk_we), .trk_wdrv(trk_wdrv), .trk_wcyl(trk_wcyl),
        .trk_rdrv(trk_rdrv), .trk_rcyl(trk_rcyl)
    );

    assign irq = irq_pend & dor_q[3];
endmodule

// File: rtl/fdc_cmd_seq_chk.sv
module fdc_cmd_seq_chk (
    input logic       clk,
    input logic       rst,
    input logic       dor_wr,
    input logic [7:0] dor_q,
    input logic       dat_wr,
    input logic       dat_rd,
    input logic [7:0] msr,
    input logic       irq
);
    assert_msr_legal_R1: assert property (@(posedge clk) disable iff (rst)
        dor_q[2] |-> (msr == 8'h80 || msr == 8'h90 || msr == 8'h10 || msr == 8'hD0));

    assert_idle_read_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (msr == 8'h80 && dat_rd && !dat_wr && !dor_wr) |=> (msr == 8'h80));

    assert_result_write_ignored_R2: assert property (@(posedge clk) disable iff (rst)
        (msr == 8'hD0 && dat_wr && !dat_rd && !dor_wr) |=> (msr[7:6] == 2'b11));

    assert_result_read_clears_irq_R8: assert property (@(posedge clk) disable iff (rst)
        (msr[7:6] == 2'b11 && dat_rd && !dor_wr) |=> !irq);

    assert_irq_follows_exec_R8: assert property (@(posedge clk) disable iff (rst)
        ($rose(irq) && $past(dor_q[3])) |-> ($past(msr) == 8'h10));

    assert_reset_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        !dor_q[2] |-> (msr == 8'h00 && !irq));
endmodule

bind fdc_cmd_seq fdc_cmd_seq_chk u_chk (
    .clk(clk), .rst(rst), .dor_wr(dor_wr), .dor_q(dor_q),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .msr(msr), .irq(irq)
);

// File: tb/fdc_cmd_seq_test.sv
module fdc_cmd_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int EXEC       = 16;
    localparam int NDRV       = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            dor_wr = 1'b0;
    logic [7:0]      dor_wdata = 8'h00;
    logic [7:0]      dor_q;
    logic [1:0]      drv_sel;
    logic [NDRV-1:0] motor_en;
    logic            dat_wr = 1'b0;
    logic            dat_rd = 1'b0;
    logic [7:0]      dat_wdata = 8'h00;
    logic [7:0]      dat_rdata;
    logic [7:0]      msr;
    logic            irq;

    fdc_cmd_seq #(.N_DRIVES(NDRV), .EXEC_CYCLES(EXEC)) uut (
        .clk(clk), .rst(rst), .dor_wr(dor_wr), .dor_wdata(dor_wdata), .dor_q(dor_q),
        .drv_sel(drv_sel), .motor_en(motor_en), .dat_wr(dat_wr), .dat_rd(dat_rd),
        .dat_wdata(dat_wdata), .dat_rdata(dat_rdata), .msr(msr), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] trk_m [NDRV];
    bit         sns_v = 1'b0;
    logic [7:0] sns_s0 = 8'h00;
    logic [7:0] sns_c = 8'h00;
    logic [7:0] xp [8];

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); dat_wr = 1'b1; dat_wdata = b;
        @(negedge clk); dat_wr = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk); b = dat_rdata; dat_rd = 1'b1;
        @(negedge clk); dat_rd = 1'b0;
    endtask

    task automatic set_dor(input logic [7:0] v);
        @(negedge clk); dor_wr = 1'b1; dor_wdata = v;
        @(negedge clk); dor_wr = 1'b0;
    endtask

    task automatic finish_exec(input bool_irq_on);
        repeat (EXEC - 1) @(negedge clk);
        chk("R10 still busy one cycle before end", msr, 8'h10);
        @(negedge clk);
        chk("R8 irq raised at end of execution", {7'b0, irq}, {7'b0, bool_irq_on});
    endtask

    task automatic seek_cmd(input logic [1:0] drv, input logic [7:0] cyl, input bit recal);
        put(recal ? 8'h07 : 8'h0F);
        put({6'b0, drv});
        if (!recal) put(cyl);
        finish_exec(1'b1);
        chk("R4 idle after seek with no status phase", msr, 8'h80);
        trk_m[drv] = recal ? 8'h00 : cyl;
        sns_v = 1'b1; sns_s0 = 8'h20 | {6'b0, drv}; sns_c = trk_m[drv];
    endtask

    task automatic sense_int();
        logic [7:0] b;
        put(8'h08);
        chk("R8 irq cleared by sense interrupt opcode", {7'b0, irq}, 8'h00);
        chk("R5 status phase after sense interrupt", msr, 8'hD0);
        get(b); chk("R5 sense ST0", b, sns_v ? sns_s0 : 8'h80);
        get(b); chk("R5 sense cylinder", b, sns_v ? sns_c : 8'h00);
        chk("R5 idle after two bytes", msr, 8'h80);
        sns_v = 1'b0;
    endtask

    task automatic sense_drv(input logic [1:0] drv, input logic head);
        logic [7:0] b;
        put(8'h04);
        put({5'b0, head, drv});
        chk("R6 sense drive enters status phase", msr, 8'hD0);
        get(b);
        chk("R6 sense drive ST3", b,
            8'h20 | ((trk_m[drv] == 8'h00) ? 8'h10 : 8'h00) | {5'b0, head, drv});
        chk("R6 idle after ST3", msr, 8'h80);
    endtask

    function automatic logic [7:0] xfer_exp(input int i);
        logic e;
        e = (xp[3] == xp[5]);
        case (i)
            0: return {e ? 2'b01 : 2'b00, 3'b000, xp[0][2], xp[0][1:0]};
            1: return e ? 8'h80 : 8'h00;
            2: return 8'h00;
            3: return xp[1];
            4: return xp[2];
            5: return e ? 8'h01 : xp[3] + 8'h01;
            default: return xp[4];
        endcase
    endfunction

    task automatic xfer(input logic [7:0] op);
        logic [7:0] b;
        put(op);
        chk("R3 argument phase after transfer opcode", msr, 8'h90);
        for (int i = 0; i < 8; i++) put(xp[i]);
        finish_exec(1'b1);
        chk("R3 status phase after transfer", msr, 8'hD0);
        for (int i = 0; i < 7; i++) begin
            get(b);
            chk($sformatf("R3 transfer status byte %0d", i), b, xfer_exp(i));
            if (i == 0) chk("R8 irq cleared by first status read", {7'b0, irq}, 8'h00);
        end
        chk("R3 idle after seven bytes", msr, 8'h80);
    endtask

    task automatic one_byte_cmd(input logic [7:0] op, input logic [7:0] exp, input string tag);
        logic [7:0] b;
        put(op);
        chk(tag, msr, 8'hD0);
        get(b);
        chk(tag, b, exp);
        chk(tag, msr, 8'h80);
    endtask

    function automatic bit known_op(input logic [7:0] op);
        return op == 8'h46 || op == 8'hC5 || op == 8'h0F || op == 8'h07 ||
               op == 8'h08 || op == 8'h03 || op == 8'h04 || op == 8'h10;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [7:0] b;
        void'($urandom(32'h5EED_F10B));
        for (int i = 0; i < NDRV; i++) trk_m[i] = 8'h00;

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R9 reset register value", dor_q, 8'h00);
        chk("R9 msr held at zero in reset", msr, 8'h00);
        chk("R9 irq low in reset", {7'b0, irq}, 8'h00);

        // R9: data write while held in reset is ignored
        put(8'h10);
        set_dor(8'h0C);
        chk("R9 write during reset ignored", msr, 8'h80);

        // R9: output fields
        set_dor(8'hAE);
        chk("R9 drive select bits", {6'b0, drv_sel}, 8'h02);
        chk("R9 motor enable bits", {4'b0, motor_en}, 8'h0A);
        chk("R1 idle status", msr, 8'h80);
        set_dor(8'h0C);

        // R5: nothing pending
        sense_int();

        // R2 + R6: write during status phase ignored
        put(8'h10);
        put(8'h55);
        chk("R2 write during status phase ignored", msr, 8'hD0);
        get(b);
        chk("R6 version byte", b, 8'h90);
        chk("R6 idle after version", msr, 8'h80);

        // R2: read during argument phase ignored
        put(8'h0F);
        get(b);
        chk("R2 read during argument phase ignored", msr, 8'h90);
        chk("R2 read data is zero outside status", b, 8'h00);
        put(8'h00);
        chk("R1 still taking arguments", msr, 8'h90);
        put(8'h05);
        chk("R1 busy during execution", msr, 8'h10);
        finish_exec(1'b1);
        trk_m[0] = 8'h05; sns_v = 1'b1; sns_s0 = 8'h20; sns_c = 8'h05;
        sense_int();

        // R8: interrupt masked by register bit 3
        set_dor(8'h04);
        put(8'h0F); put(8'h01); put(8'h09);
        finish_exec(1'b0);
        trk_m[1] = 8'h09; sns_v = 1'b1; sns_s0 = 8'h21; sns_c = 8'h09;
        set_dor(8'h0C);
        chk("R8 pending irq appears when unmasked", {7'b0, irq}, 8'h01);
        sense_int();

        // R6: specify
        put(8'h03);
        chk("R6 specify takes arguments", msr, 8'h90);
        put(8'hDF); put(8'h02);
        chk("R6 specify returns to idle", msr, 8'h80);

        // R7: invalid opcode
        one_byte_cmd(8'hFF, 8'h80, "R7 invalid opcode");

        // R9: reset write lands on the finishing edge of a seek from 5 to 0
        put(8'h0F); put(8'h00); put(8'h00);
        repeat (EXEC - 1) @(negedge clk);
        dor_wr = 1'b1; dor_wdata = 8'h08;
        @(negedge clk);
        dor_wr = 1'b0;
        chk("R9 reset wins over completion msr", msr, 8'h00);
        chk("R9 reset wins over completion irq", {7'b0, irq}, 8'h00);
        set_dor(8'h0C);
        chk("R9 idle after reset released", msr, 8'h80);
        chk("R9 no irq after collision", {7'b0, irq}, 8'h00);
        sns_v = 1'b0;
        sense_int();
        sense_drv(2'd0, 1'b0);

        // directed end-of-cylinder transfer
        xp[0] = 8'h05; xp[1] = 8'h10; xp[2] = 8'h01; xp[3] = 8'h12;
        xp[4] = 8'h02; xp[5] = 8'h12; xp[6] = 8'h1B; xp[7] = 8'hFF;
        xfer(8'h46);

        // constrained random mix
        for (int n = 0; n < 60; n++) begin
            int unsigned sel;
            logic [1:0]  d;
            sel = $urandom_range(0, 7);
            d   = 2'($urandom_range(0, 3));
            case (sel)
                0: seek_cmd(d, 8'($urandom_range(0, 79)), 1'b0);
                1: seek_cmd(d, 8'h00, 1'b1);
                2: sense_int();
                3: begin
                    xp[5] = 8'($urandom_range(8, 18));
                    xp[0] = {5'b0, 1'($urandom_range(0, 1)), d};
                    xp[1] = 8'($urandom_range(0, 79));
                    xp[2] = {7'b0, xp[0][2]};
                    xp[3] = ($urandom_range(0, 3) == 0) ? xp[5] : 8'($urandom_range(1, 7));
                    xp[4] = 8'($urandom_range(0, 3));
                    xp[6] = 8'h1B; xp[7] = 8'hFF;
                    xfer($urandom_range(0, 1) ? 8'h46 : 8'hC5);
                end
                4: sense_drv(d, 1'($urandom_range(0, 1)));
                5: one_byte_cmd(8'h10, 8'h90, "R6 version byte random");
                6: begin
                    logic [7:0] op;
                    op = 8'($urandom_range(0, 255));
                    while (known_op(op)) op = 8'($urandom_range(0, 255));
                    one_byte_cmd(op, 8'h80, "R7 random invalid opcode");
                end
                default: begin
                    put(8'h03); put(8'($urandom)); put(8'($urandom));
                    chk("R6 random specify idle", msr, 8'h80);
                end
            endcase
        end

        summary();
    end
endmodule